// File: doc/BRIEF.md
# Preface-Letter BCD Parameter Parser

This block sits behind a byte-serial bus listener and turns a stream of accepted 7-bit ASCII characters into stored parallel BCD settings. Each strobed character is either a preface letter or a decimal numeral. A preface letter chooses one of five parameters: frequency, amplitude, vernier, leveling and delay. Numerals carry no tag of their own. Each numeral is shifted into the digit register of the parameter named by the most recent preface. A command such as "A1234" therefore leaves four amplitude digits in the amplitude register.

Each parameter register is a shift register of BCD nibbles. A preface clears it, and each numeral then enters at the least significant nibble while the earlier digits move up, so the most significant digit is sent first. Every register change comes with a one-cycle update pulse for that parameter. Every strobed character, whether used or ignored, returns a one-cycle done pulse that the listener uses to release its ready-for-data line. Digit counts, preface letters and turn-on values are parameters.

Top module: `ascii_param_parser`

## Requirements
- R1: While reset is low and on the first cycle after it, the registers hold their turn-on values: frequency 0x001000, amplitude 0x0100, vernier 0x500, leveling 0x1, delay 0x00. At the same time `upd` and `done` are 0 and no parameter is selected.
- R2: A strobed preface letter selects its parameter and clears that register to zero on the clock edge that samples the strobe. The letters are 'F' (0x46) for frequency, 'A' (0x41) for amplitude, 'V' (0x56) for vernier, 'L' (0x4C) for leveling and 'D' (0x44) for delay.
- R3: A strobed numeral (0x30 to 0x39) moves the selected register up one nibble and places the value char[3:0] in bits [3:0], so digits arrive most significant first.
- R4: When more numerals arrive than the register has nibbles, the top nibble falls off and the register keeps the latest digits.
- R5: A numeral that arrives after reset and before any preface changes no register and raises no `upd` bit.
- R6: Any other character, including lowercase letters, punctuation and 0x7F, changes no register, raises no `upd` bit and leaves the current selection in place.
- R7: `done` is high for exactly one cycle after the edge that samples each strobe, ignored characters included, and stays low when there is no strobe.
- R8: A new preface moves the selection, and the other parameters keep their values.
- R9: `upd` bits, in the order bit0 frequency, bit1 amplitude, bit2 vernier, bit3 leveling, bit4 delay, pulse for one cycle together with the register change they report. At most one bit is set at a time.
- R10: While `char_stb` is low, `char_in` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_stb | input | 1 | One-cycle strobe for an accepted character |
| char_in | input | 7 | ASCII character |
| freq_bcd | output | 4*FREQ_DIG | Frequency digits, BCD |
| ampl_bcd | output | 4*AMPL_DIG | Amplitude digits, BCD |
| vern_bcd | output | 4*VERN_DIG | Vernier digits, BCD |
| lvl_bcd | output | 4*LVL_DIG | Leveling digits, BCD |
| dly_bcd | output | 4*DLY_DIG | Delay digits, BCD |
| upd | output | 5 | Per-parameter update pulse |
| done | output | 1 | Character-processed pulse |

## Verification
Each result has one register stage. The register contents, `upd` and `done` all change on the clock edge that samples the strobe and can be read one cycle later. The bench drives each character on a falling edge and compares every output on the next falling edge against a model that holds the expected values. After the pulse cycle it runs an idle check with the strobe low, which confirms that `upd` and `done` have returned to 0 and that a letter on the data lines has no effect.

// File: rtl/ascii_param_parser.sv
module ascii_param_parser #(
  parameter int FREQ_DIG = 6,
  parameter int AMPL_DIG = 4,
  parameter int VERN_DIG = 3,
  parameter int LVL_DIG  = 1,
  parameter int DLY_DIG  = 2,
  parameter logic [6:0] KEY_FREQ = 7'h46,
  parameter logic [6:0] KEY_AMPL = 7'h41,
  parameter logic [6:0] KEY_VERN = 7'h56,
  parameter logic [6:0] KEY_LVL  = 7'h4C,
  parameter logic [6:0] KEY_DLY  = 7'h44,
  parameter logic [4*FREQ_DIG-1:0] FREQ_INIT = 24'h001000,
  parameter logic [4*AMPL_DIG-1:0] AMPL_INIT = 16'h0100,
  parameter logic [4*VERN_DIG-1:0] VERN_INIT = 12'h500,
  parameter logic [4*LVL_DIG-1:0]  LVL_INIT  = 4'h1,
  parameter logic [4*DLY_DIG-1:0]  DLY_INIT  = 8'h00
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    char_stb,
  input  logic [6:0]              char_in,
  output logic [4*FREQ_DIG-1:0]   freq_bcd,
  output logic [4*AMPL_DIG-1:0]   ampl_bcd,
  output logic [4*VERN_DIG-1:0]   vern_bcd,
  output logic [4*LVL_DIG-1:0]    lvl_bcd,
  output logic [4*DLY_DIG-1:0]    dly_bcd,
  output logic [4:0]              upd,
  output logic                    done
);
  localparam int WF = 4*FREQ_DIG;
  localparam int WA = 4*AMPL_DIG;
  localparam int WV = 4*VERN_DIG;
  localparam int WL = 4*LVL_DIG;
  localparam int WD = 4*DLY_DIG;

  logic [4:0] sel;
  logic [4:0] hit;
  logic [4:0] shift;
  logic       is_num;
  logic [3:0] num;

  assign is_num = (char_in >= 7'h30) && (char_in <= 7'h39);
  assign num    = char_in[3:0];

  assign hit = {5{char_stb}} & {char_in == KEY_DLY, char_in == KEY_LVL,
                                char_in == KEY_VERN, char_in == KEY_AMPL,
                                char_in == KEY_FREQ};
  assign shift = (char_stb && is_num) ? sel : 5'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel  <= '0;
      upd  <= '0;
      done <= 1'b0;
    end else begin
      if (|hit) sel <= hit;
      upd  <= hit | shift;
      done <= char_stb;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        freq_bcd <= FREQ_INIT;
    else if (hit[0])   freq_bcd <= '0;
    else if (shift[0]) freq_bcd <= WF'({freq_bcd, num});
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        ampl_bcd <= AMPL_INIT;
    else if (hit[1])   ampl_bcd <= '0;
    else if (shift[1]) ampl_bcd <= WA'({ampl_bcd, num});
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        vern_bcd <= VERN_INIT;
    else if (hit[2])   vern_bcd <= '0;
    else if (shift[2]) vern_bcd <= WV'({vern_bcd, num});
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        lvl_bcd <= LVL_INIT;
    else if (hit[3])   lvl_bcd <= '0;
    else if (shift[3]) lvl_bcd <= WL'({lvl_bcd, num});
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        dly_bcd <= DLY_INIT;
    else if (hit[4])   dly_bcd <= '0;
    else if (shift[4]) dly_bcd <= WD'({dly_bcd, num});
  end
endmodule

module ascii_param_parser_chk #(
  parameter int WF = 24,
  parameter int WA = 16,
  parameter logic [6:0] KEY_FREQ = 7'h46,
  parameter logic [6:0] KEY_AMPL = 7'h41
) (
  input logic          clk,
  input logic          rst_n,
  input logic          char_stb,
  input logic [6:0]    char_in,
  input logic [WF-1:0] freq_bcd,
  input logic [WA-1:0] ampl_bcd,
  input logic [4:0]    upd,
  input logic          done
);
  AST_DONE_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n) char_stb |=> done); // R7
  AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !char_stb |=> !done); // R7
  AST_UPD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(upd)); // R9
  AST_NO_UPD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !char_stb |=> upd == 5'b0); // R10
  AST_FREQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (char_stb && char_in == KEY_FREQ) |=> (freq_bcd == '0 && upd[0])); // R2
  AST_AMPL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (char_stb && char_in == KEY_AMPL) |=> (ampl_bcd == '0 && upd[1])); // R2
  AST_FREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !upd[0] |-> $stable(freq_bcd)); // R9
  AST_AMPL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !upd[1] |-> $stable(ampl_bcd)); // R9
  AST_AMPL_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
    (upd[1] && ampl_bcd != '0) |-> ampl_bcd[3:0] == $past(char_in[3:0])); // R3
endmodule

bind ascii_param_parser ascii_param_parser_chk #(
  .WF(WF), .WA(WA), .KEY_FREQ(KEY_FREQ), .KEY_AMPL(KEY_AMPL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .char_stb(char_stb), .char_in(char_in),
  .freq_bcd(freq_bcd), .ampl_bcd(ampl_bcd), .upd(upd), .done(done)
);

// File: tb/sim_ascii_param_parser.sv
`timescale 1ns/1ps
module sim_ascii_param_parser;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic char_stb = 1'b0;
  logic [6:0] char_in = 7'h00;
  logic [23:0] freq_bcd;
  logic [15:0] ampl_bcd;
  logic [11:0] vern_bcd;
  logic [3:0]  lvl_bcd;
  logic [7:0]  dly_bcd;
  logic [4:0]  upd;
  logic        done;

  int checks = 0;
  int fails = 0;
  bit ended = 0;

  logic [23:0] m_reg [5];
  logic [23:0] m_mask [5];
  int          m_sel;
  logic [4:0]  m_upd;

  always #2.5 clk = ~clk;

  ascii_param_parser u0 (
    .clk(clk), .rst_n(rst_n), .char_stb(char_stb), .char_in(char_in),
    .freq_bcd(freq_bcd), .ampl_bcd(ampl_bcd), .vern_bcd(vern_bcd),
    .lvl_bcd(lvl_bcd), .dly_bcd(dly_bcd), .upd(upd), .done(done)
  );

  function automatic int key_index(input logic [6:0] c);
    case (c)
      7'h46: return 0;
      7'h41: return 1;
      7'h56: return 2;
      7'h4C: return 3;
      7'h44: return 4;
      default: return -1;
    endcase
  endfunction

  function automatic string tag_of(input logic [6:0] c);
    if (key_index(c) >= 0) return "R2/R8";
    if (c >= 7'h30 && c <= 7'h39) return (m_sel < 0) ? "R5" : "R3/R4";
    return "R6";
  endfunction

  task automatic model_reset();
    m_reg[0] = 24'h001000; m_reg[1] = 24'h000100; m_reg[2] = 24'h000500;
    m_reg[3] = 24'h000001; m_reg[4] = 24'h000000;
    m_mask[0] = 24'hFFFFFF; m_mask[1] = 24'h00FFFF; m_mask[2] = 24'h000FFF;
    m_mask[3] = 24'h00000F; m_mask[4] = 24'h0000FF;
    m_sel = -1;
    m_upd = '0;
  endtask

  task automatic model_char(input logic [6:0] c);
    int k;
    k = key_index(c);
    m_upd = '0;
    if (k >= 0) begin
      m_sel = k; m_reg[k] = '0; m_upd[k] = 1'b1;
    end else if (c >= 7'h30 && c <= 7'h39 && m_sel >= 0) begin
      m_reg[m_sel] = ((m_reg[m_sel] << 4) | {20'h0, c[3:0]}) & m_mask[m_sel];
      m_upd[m_sel] = 1'b1;
    end
  endtask

  task automatic compare(input string tag, input logic exp_done, input logic [4:0] exp_upd);
    logic [77:0] act, exp;
    act = {done, upd, freq_bcd, ampl_bcd, vern_bcd, lvl_bcd, dly_bcd};
    exp = {exp_done, exp_upd, m_reg[0], m_reg[1][15:0], m_reg[2][11:0],
           m_reg[3][3:0], m_reg[4][7:0]};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [6:0] c);
    string t;
    t = tag_of(c);
    char_in = c; char_stb = 1'b1;
    @(posedge clk); @(negedge clk);
    char_stb = 1'b0;
    model_char(c);
    compare({t, " R7 R9"}, 1'b1, m_upd);
  endtask

  task automatic idle_check(input logic [6:0] c);
    char_in = c; char_stb = 1'b0;
    @(posedge clk); @(negedge clk);
    compare("R10 R7", 1'b0, 5'b0);
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send(7'(s[i]));
  endtask

  function automatic logic [6:0] rand_char();
    int r;
    r = $urandom_range(0, 9);
    if (r < 5) return 7'(8'h30 + $urandom_range(0, 9));
    if (r < 8) begin
      case ($urandom_range(0, 4))
        0: return 7'h46; 1: return 7'h41; 2: return 7'h56; 3: return 7'h4C;
        default: return 7'h44;
      endcase
    end
    return 7'($urandom_range(0, 127));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1", 1'b0, 5'b0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    compare("R1", 1'b0, 5'b0);
    send("7");            // R5 digit before preface
    send("z");            // R6
    send_str("A1234");    // R3
    idle_check(7'h46);    // R10
    send_str("F123456789"); // R4
    send_str("a#");       // R6 keeps selection
    send(7'h7F);          // R6
    send("5");            // R3 still frequency
    send_str("V9");       // R8
    send_str("L73");      // R4 single digit
    send_str("D");        // R2 clear
    idle_check(7'h30);
    for (int n = 0; n < 400; n++) begin
      send(rand_char());
      if ($urandom_range(0, 7) == 0) idle_check(rand_char());
    end
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule